// File: doc/BRIEF.md
# Embedded Core Memory Programmed-I/O Loader

This block gives a host a register window through which it fills the instruction memory and the data memory of a small embedded core one 32-bit word at a time, with no DMA engine involved. For each memory the host writes a control register holding a byte offset and auto-increment enables. It then streams words through a data register, so that a whole image goes in as one run of writes. The host assembles each word from its byte stream with the first byte in bits 7:0.

Instruction memory is split into 256-byte blocks. Each block keeps a tag and a secure bit next to its data. Every instruction-memory word write stamps the block that holds the current offset with the tag register and the secure flag from the control register. The host normally bumps the tag once per block and loads secure and non-secure code in separate passes. A boot-vector register holds the start address that the core will use. Reads of both data registers, with an optional auto-increment on read, let the host verify what it loaded.

The bus front end is a two-state machine. In ST_IDLE, req_ready is high and requests are accepted. A write completes in its accept cycle and the machine stays in ST_IDLE (transition IDLE_WRITE). An accepted read moves it to ST_RESP (transition IDLE_TO_RESP). In ST_RESP, rsp_valid is high, req_ready is low, and the machine returns to ST_IDLE on the next edge (transition RESP_TO_IDLE).

Top module: `cpu_mem_pio_loader`

## Requirements
- R1: After reset both offsets, both auto-increment enables, the secure flag, the tag register, every block's tag and secure bit, the boot vector and the overrun flag are zero, and req_ready is high.
- R2: A read accepted on an edge (req_valid and req_ready both high) produces rsp_valid with its data during the following cycle, and req_ready is low in that cycle. A write completes in its accept cycle and produces no response.
- R3: The register word map is fixed by byte address: 0x00 instruction control, 0x04 instruction data, 0x08 tag (bits 15:0), 0x0C data-memory control, 0x10 data-memory data, 0x14 boot vector, 0x18 block info. Writes to any other address change nothing, and reads of them return zero.
- R4: In both control registers, bits 15:0 are the byte offset, with bits 1:0 read back as zero. Bit 24 enables auto-increment on write and bit 25 enables auto-increment on read. A data write stores the word at word index offset/4. It then advances the offset by 4 only when bit 24 is set, so without bit 24 repeated writes overwrite the same word.
- R5: A data-register read returns the word at the current offset, then advances the offset by 4 only when bit 25 is set. Streaming reads cross block boundaries without a gap.
- R6: Each instruction data write that lands in memory records the current tag register value and the secure flag against block offset/256, replacing earlier values. A read of 0x18 returns the secure bit in bit 31 and the tag in bits 15:0 for the block that holds the current offset.
- R7: Bit 28 of the instruction control register is the secure flag. Blocks written while it is set report secure in block info, and blocks written in an earlier non-secure pass keep reporting non-secure.
- R8: The boot vector holds the last value written to 0x14. It drives boot_addr and is read back at 0x14, and writes to other registers leave it unchanged.
- R9: A data write whose word index is at or beyond the configured depth of its memory is dropped, and it sets the sticky overrun output. Reads at such offsets return zero, and so does block info.
- R10: Offsets are 16-bit byte addresses spanning 64 KiB. Advancing from 0xFFFC wraps the offset to 0x0000.
- R11: The data-memory path has no tags and no secure flag: bit 28 of its control register is ignored and read back as zero. Its accesses move neither the instruction offset nor any block info.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| boot_addr | output | 32 | Boot-vector register value |
| overrun | output | 1 | Sticky flag for writes beyond configured memory |

## Verification
The bench builds the block with a 256-word instruction memory (four tagged blocks) and a 64-word data memory. With these sizes the configured end of instruction memory sits at offset 0x3FC, so the last in-range word, the first dropped word and the zero read-back past the end take only a few accesses each. A full 64-word stream per block stays short enough to load three blocks in distinct tag and secure passes. It then checks the block-boundary crossing on streamed reads and the wrap from 0xFFFC.

// File: rtl/pio_loader_pkg.sv
package pio_loader_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    // Register word indices (byte address / 4)
    localparam logic [5:0] RI_IM_CTRL  = 6'd0;
    localparam logic [5:0] RI_IM_DATA  = 6'd1;
    localparam logic [5:0] RI_IM_TAG   = 6'd2;
    localparam logic [5:0] RI_DM_CTRL  = 6'd3;
    localparam logic [5:0] RI_DM_DATA  = 6'd4;
    localparam logic [5:0] RI_BOOT     = 6'd5;
    localparam logic [5:0] RI_BLK_INFO = 6'd6;

    // Control register bit positions
    localparam int BIT_AINC_W = 24;
    localparam int BIT_AINC_R = 25;
    localparam int BIT_SEC    = 28;

    typedef struct packed {
        logic [15:0] off;
        logic        aw;
        logic        ar;
        logic        sec;
    } port_ctl_t;

endpackage

// File: rtl/pio_bus_fsm.sv
module pio_bus_fsm
    import pio_loader_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic wr_acc,
    output logic rd_acc,
    output logic rsp_valid
);

    bus_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid && !req_write) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: req_ready = 1'b0;
        endcase
        wr_acc = req_valid && req_ready && req_write;
        rd_acc = req_valid && req_ready && !req_write;
    end

endmodule

// File: rtl/pio_word_ram.sv
module pio_word_ram #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [WIDTH-1:0]         wdata,
    output logic [WIDTH-1:0]         rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/pio_block_tags.sv
module pio_block_tags #(
    parameter int BLOCKS = 16,
    parameter int TAG_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(BLOCKS)-1:0] blk,
    input  logic [TAG_W-1:0]          tag,
    input  logic                      sec,
    output logic [TAG_W-1:0]          rd_tag,
    output logic                      rd_sec
);

    logic [TAG_W-1:0] tag_q [BLOCKS];
    logic [BLOCKS-1:0] sec_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) tag_q[b] <= '0;
            sec_q <= '0;
        end else if (we) begin
            tag_q[blk] <= tag;
            sec_q[blk] <= sec;
        end
    end

    assign rd_tag = tag_q[blk];
    assign rd_sec = sec_q[blk];

endmodule

// File: rtl/cpu_mem_pio_loader.sv
module cpu_mem_pio_loader
    import pio_loader_pkg::*;
#(
    parameter int IMEM_DEPTH = 1024,
    parameter int DMEM_DEPTH = 512,
    parameter int TAG_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] boot_addr,
    output logic              overrun
);

    localparam int IM_AW  = $clog2(IMEM_DEPTH);
    localparam int DM_AW  = $clog2(DMEM_DEPTH);
    localparam int BLOCKS = IMEM_DEPTH / 64;
    localparam int PAD_W  = DATA_W - 1 - TAG_W;

    logic wr_acc, rd_acc;
    logic [5:0] reg_idx;
    logic unused_lsb;

    port_ctl_t im_ctl, dm_ctl;
    logic [TAG_W-1:0]  im_tag;
    logic [DATA_W-1:0] boot_q, rdata_q, rd_mux;
    logic              ovr_q;
    logic              im_in, dm_in, im_wr, im_rd, dm_wr, dm_rd;
    logic [DATA_W-1:0] im_rdata, dm_rdata;
    logic [TAG_W-1:0]  blk_tag;
    logic              blk_sec;

    assign reg_idx    = req_addr[7:2];
    assign unused_lsb = ^req_addr[1:0];

    pio_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .wr_acc    (wr_acc),
        .rd_acc    (rd_acc),
        .rsp_valid (rsp_valid)
    );

    assign im_in = 32'(im_ctl.off[15:2]) < 32'(IMEM_DEPTH);
    assign dm_in = 32'(dm_ctl.off[15:2]) < 32'(DMEM_DEPTH);
    assign im_wr = wr_acc && (reg_idx == RI_IM_DATA);
    assign im_rd = rd_acc && (reg_idx == RI_IM_DATA);
    assign dm_wr = wr_acc && (reg_idx == RI_DM_DATA);
    assign dm_rd = rd_acc && (reg_idx == RI_DM_DATA);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            im_ctl <= '0;
        end else if (wr_acc && reg_idx == RI_IM_CTRL) begin
            im_ctl <= '{off: {req_wdata[15:2], 2'b00},
                        aw:  req_wdata[BIT_AINC_W],
                        ar:  req_wdata[BIT_AINC_R],
                        sec: req_wdata[BIT_SEC]};
        end else if ((im_wr && im_ctl.aw) || (im_rd && im_ctl.ar)) begin
            im_ctl.off <= im_ctl.off + 16'd4;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dm_ctl <= '0;
        end else if (wr_acc && reg_idx == RI_DM_CTRL) begin
            dm_ctl <= '{off: {req_wdata[15:2], 2'b00},
                        aw:  req_wdata[BIT_AINC_W],
                        ar:  req_wdata[BIT_AINC_R],
                        sec: 1'b0};
        end else if ((dm_wr && dm_ctl.aw) || (dm_rd && dm_ctl.ar)) begin
            dm_ctl.off <= dm_ctl.off + 16'd4;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            im_tag <= '0;
            boot_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (wr_acc && reg_idx == RI_IM_TAG) im_tag <= req_wdata[TAG_W-1:0];
            if (wr_acc && reg_idx == RI_BOOT)   boot_q <= req_wdata;
            if ((im_wr && !im_in) || (dm_wr && !dm_in)) ovr_q <= 1'b1;
        end
    end

    pio_word_ram #(.DEPTH(IMEM_DEPTH), .WIDTH(DATA_W)) u_imem (
        .clk   (clk),
        .we    (im_wr && im_in),
        .addr  (im_ctl.off[IM_AW+1:2]),
        .wdata (req_wdata),
        .rdata (im_rdata)
    );

    pio_word_ram #(.DEPTH(DMEM_DEPTH), .WIDTH(DATA_W)) u_dmem (
        .clk   (clk),
        .we    (dm_wr && dm_in),
        .addr  (dm_ctl.off[DM_AW+1:2]),
        .wdata (req_wdata),
        .rdata (dm_rdata)
    );

    pio_block_tags #(.BLOCKS(BLOCKS), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (im_wr && im_in),
        .blk    (im_ctl.off[IM_AW+1:8]),
        .tag    (im_tag),
        .sec    (im_ctl.sec),
        .rd_tag (blk_tag),
        .rd_sec (blk_sec)
    );

    always_comb begin
        rd_mux = '0;
        unique case (reg_idx)
            RI_IM_CTRL:  rd_mux = {3'b0, im_ctl.sec, 2'b0, im_ctl.ar, im_ctl.aw, 8'b0, im_ctl.off};
            RI_IM_DATA:  rd_mux = im_in ? im_rdata : '0;
            RI_IM_TAG:   rd_mux = {{(DATA_W-TAG_W){1'b0}}, im_tag};
            RI_DM_CTRL:  rd_mux = {6'b0, dm_ctl.ar, dm_ctl.aw, 8'b0, dm_ctl.off};
            RI_DM_DATA:  rd_mux = dm_in ? dm_rdata : '0;
            RI_BOOT:     rd_mux = boot_q;
            RI_BLK_INFO: rd_mux = im_in ? {blk_sec, {PAD_W{1'b0}}, blk_tag} : '0;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_acc) rdata_q <= rd_mux;
    end

    assign rsp_rdata = rdata_q;
    assign boot_addr = boot_q;
    assign overrun   = ovr_q;

endmodule

// File: rtl/pio_loader_chk.sv
module pio_loader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [5:0]  reg_idx,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [31:0] boot_addr,
    input logic        overrun
);

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid); // R2

    AST_RSP_ONLY_FOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req_valid && req_ready && !req_write)) |=> !rsp_valid); // R2

    AST_NOT_READY_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R2

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R9

    AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && req_write && reg_idx == 6'd5) |=> $stable(boot_addr)); // R8

endmodule

bind cpu_mem_pio_loader pio_loader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .reg_idx   (req_addr[7:2]),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .boot_addr (boot_addr),
    .overrun   (overrun)
);

// File: tb/cpu_mem_pio_loader_tb_top.sv
module cpu_mem_pio_loader_tb_top;

    localparam int IMD = 256;
    localparam int DMD = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic        req_ready, rsp_valid, overrun;
    logic [31:0] rsp_rdata, boot_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q [$];
    string       req_q [$];

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    cpu_mem_pio_loader #(.IMEM_DEPTH(IMD), .DMEM_DEPTH(DMD), .TAG_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .boot_addr(boot_addr),
        .overrun(overrun)
    );

    function automatic logic [31:0] pat(int i);
        logic [7:0] b [4];
        for (int k = 0; k < 4; k++) b[k] = 8'((4 * i + k) * 7 + 1);
        return {b[3], b[2], b[1], b[0]};   // byte 0 in bits 7:0
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // driver: pushes the expected item, then issues the read
    task automatic rd(logic [7:0] a, logic [31:0] e, string r);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(e);
        req_q.push_back(r);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: pops and compares each response
    always @(negedge clk) begin : mon
        logic [31:0] e;
        string r;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 actual unexpected response %h expected none", rsp_rdata);
            end else begin
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(r, rsp_rdata, e);
                check("R2 ready low in response cycle", {31'b0, req_ready}, 32'h0);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 req_ready", {31'b0, req_ready}, 32'h1);
        check("R1 boot_addr", boot_addr, 32'h0);
        check("R1 overrun", {31'b0, overrun}, 32'h0);
        rd(8'h00, 32'h0, "R1 imem ctrl");
        rd(8'h08, 32'h0, "R1 tag");
        rd(8'h0C, 32'h0, "R1 dmem ctrl");
        rd(8'h14, 32'h0, "R1 boot");
        rd(8'h18, 32'h0, "R1 block info");

        // non-secure pass, blocks 0 and 1
        wr(8'h00, 32'h0100_0000);
        wr(8'h08, 32'd5);
        for (int i = 0; i < 64; i++) wr(8'h04, pat(i));
        wr(8'h08, 32'd6);
        for (int i = 64; i < 128; i++) wr(8'h04, pat(i));
        rd(8'h00, 32'h0100_0200, "R4 offset after 128 writes");

        // R7 secure pass, block 2
        wr(8'h00, 32'h1100_0200);
        rd(8'h00, 32'h1100_0200, "R7 secure ctrl readback");
        wr(8'h08, 32'd7);
        for (int i = 128; i < 192; i++) wr(8'h04, pat(i));

        // R6 R7 block info
        wr(8'h00, 32'h0000_0000);
        rd(8'h18, 32'h0000_0005, "R6 block0 tag");
        wr(8'h00, 32'h0000_0100);
        rd(8'h18, 32'h0000_0006, "R6 block1 tag");
        wr(8'h00, 32'h0000_0200);
        rd(8'h18, 32'h8000_0007, "R7 block2 secure");
        wr(8'h00, 32'h0000_02FC);
        rd(8'h18, 32'h8000_0007, "R7 block2 last word");

        // R5 streaming reads across a block boundary
        wr(8'h00, 32'h0200_00FC);
        rd(8'h04, pat(63), "R5 word 63");
        rd(8'h04, pat(64), "R5 word 64");
        rd(8'h00, 32'h0200_0104, "R5 offset after reads");
        wr(8'h00, 32'h0200_0200);
        rd(8'h04, pat(128), "R5 word 128");
        wr(8'h00, 32'h0000_0000);
        rd(8'h04, pat(0), "R5 no read increment");
        rd(8'h04, pat(0), "R5 no read increment repeat");

        // R4 no write increment
        wr(8'h00, 32'h0000_0010);
        wr(8'h04, 32'hAAAA_0001);
        wr(8'h04, 32'hBBBB_0002);
        rd(8'h00, 32'h0000_0010, "R4 offset held");
        rd(8'h04, 32'hBBBB_0002, "R4 overwrite");
        rd(8'h18, 32'h0000_0007, "R6 block0 retagged");

        // R9 overrun at configured end
        wr(8'h00, 32'h0100_03FC);
        wr(8'h04, 32'hCCCC_0003);
        check("R9 no overrun in range", {31'b0, overrun}, 32'h0);
        wr(8'h04, 32'hDDDD_0004);
        check("R9 overrun set", {31'b0, overrun}, 32'h1);
        rd(8'h00, 32'h0100_0404, "R9 offset advanced");
        rd(8'h04, 32'h0, "R9 read past end");
        rd(8'h18, 32'h0, "R9 info past end");
        wr(8'h00, 32'h0200_03FC);
        rd(8'h04, 32'hCCCC_0003, "R9 last word kept");
        rd(8'h04, 32'h0, "R9 dropped word");
        wr(8'h00, 32'h0200_0000);
        rd(8'h04, pat(0), "R9 no alias to word 0");

        // R10 wrap
        wr(8'h00, 32'h0100_FFFC);
        wr(8'h04, 32'hEEEE_0005);
        rd(8'h00, 32'h0100_0000, "R10 offset wrap");
        check("R9 overrun sticky", {31'b0, overrun}, 32'h1);

        // R11 DMEM path
        wr(8'h0C, 32'h1100_0000);
        rd(8'h0C, 32'h0100_0000, "R11 no secure bit");
        wr(8'h10, 32'h1111_0000);
        wr(8'h10, 32'h2222_0000);
        wr(8'h10, 32'h3333_0000);
        rd(8'h0C, 32'h0100_000C, "R11 dmem offset");
        rd(8'h00, 32'h0100_0000, "R11 imem offset untouched");
        rd(8'h18, 32'h0000_0007, "R11 block info untouched");
        wr(8'h0C, 32'h0200_0000);
        rd(8'h10, 32'h1111_0000, "R11 dmem word 0");
        rd(8'h10, 32'h2222_0000, "R11 dmem word 1");
        rd(8'h10, 32'h3333_0000, "R11 dmem word 2");

        // R3 unmapped
        wr(8'h1C, 32'hDEAD_BEEF);
        wr(8'h40, 32'hDEAD_BEEF);
        rd(8'h1C, 32'h0, "R3 unmapped read");
        rd(8'h40, 32'h0, "R3 unmapped read high");
        rd(8'h08, 32'h0000_0007, "R3 tag unchanged");
        rd(8'h14, 32'h0, "R3 boot unchanged");
        check("R3 boot port unchanged", boot_addr, 32'h0);

        // R8 boot vector
        wr(8'h14, 32'h0000_0500);
        check("R8 boot port", boot_addr, 32'h0000_0500);
        rd(8'h14, 32'h0000_0500, "R8 boot readback");
        wr(8'h08, 32'd9);
        check("R8 boot held", boot_addr, 32'h0000_0500);

        repeat (4) @(negedge clk);
        check("R2 all responses seen", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule